// File: doc/BRIEF.md
# Bus Acknowledge Timeout Timer

This block guards a processor against bus cycles that never finish. A strobe marks the first clock state of each machine cycle, read or write, and the block restarts its window on that strobe. If the addressed memory or I/O device acknowledges in time, the acknowledge passes straight through to the processor's ready input. If the window runs out with no acknowledge, the block drives ready itself for one cycle, so the wait state ends as though the device had answered.

When the block forces ready it also pulses an interrupt request and sets a sticky status bit, which drives a visible indicator. The status bit stays set until software asserts a clear input. A static strap turns the timeout on. With the strap low, a cycle with no acknowledge waits until reset, and the block never forces ready. The window length is the clock frequency times a time in microseconds. By default this gives 10 ms.

Top module: `bus_ack_watchdog`

## Requirements
- R1: While reset is low, and on the first cycle after it, `cpu_ready`, `tmo_irq` and `tmo_status` are 0 as long as `dev_ack` is 0.
- R2: If `cyc_start` is sampled at clock edge k and `dev_ack` stays low, then `tmo_irq` and `cpu_ready` are 1 in the cycle that follows edge k+LIMIT-1, and are 0 in every earlier cycle after edge k.
- R3: `cpu_ready` follows `dev_ack` in the same cycle, with no register on the path. An acknowledge that arrives in or before the cycle in which the timeout would fire cancels that timeout, so no `tmo_irq` is raised for that machine cycle.
- R4: A timed-out machine cycle raises `tmo_irq` for exactly one cycle. After it, neither `tmo_irq` nor a forced ready appears again until the next `cyc_start`, and a late `dev_ack` still passes through as ready.
- R5: A `cyc_start` that arrives while a window is running restarts the window from zero.
- R6: With `strap_en` at 0, the block never raises `tmo_irq`, never forces `cpu_ready`, and never sets `tmo_status`, however long the acknowledge is missing.
- R7: `tmo_status` becomes 1 on the clock edge that ends a `tmo_irq` cycle. It holds until an edge samples `flag_clr` at 1 with no `tmo_irq` in that cycle, and after that edge it reads 0.
- R8: LIMIT equals (CLK_HZ / 1,000,000) × WINDOW_US clock cycles. The defaults of 200 MHz and 10,000 µs give a 10 ms window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cyc_start | input | 1 | High for the first clock state of a machine cycle |
| dev_ack | input | 1 | Acknowledge from the addressed device |
| strap_en | input | 1 | Static strap that enables the timeout |
| flag_clr | input | 1 | Software clear for the sticky status bit |
| cpu_ready | output | 1 | Ready to the processor: the device acknowledge or a forced ready |
| tmo_irq | output | 1 | One-cycle timeout interrupt request |
| tmo_status | output | 1 | Sticky timeout status; drives the indicator |

## Verification
`cpu_ready` and `tmo_irq` are combinational from the counter and `dev_ack`, so the bench sets `dev_ack` on a falling edge and reads both outputs 1 ns later, in that same cycle. The forced ready is due in the LIMIT-th cycle after the edge that samples `cyc_start`. The bench counts cycles from that edge, sweeping the acknowledge delay from zero (no acknowledge) to beyond the window, and checks every cycle of each run. `tmo_status` is registered, so the bench reads it in the cycle after the interrupt pulse or after the clear.

// File: rtl/bus_ack_watchdog.sv
module bus_ack_watchdog #(
  parameter int unsigned CLK_HZ    = 200_000_000,
  parameter int unsigned WINDOW_US = 10_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cyc_start,
  input  logic dev_ack,
  input  logic strap_en,
  input  logic flag_clr,
  output logic cpu_ready,
  output logic tmo_irq,
  output logic tmo_status
);
  localparam int unsigned LIMIT = (CLK_HZ / 1_000_000) * WINDOW_US;
  localparam int unsigned CW    = (LIMIT > 2) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic          waiting;
  logic [CW-1:0] cnt;
  logic          at_limit;

  assign at_limit  = (cnt == LAST);
  assign tmo_irq   = waiting && at_limit && strap_en && !dev_ack;
  assign cpu_ready = dev_ack || tmo_irq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      waiting <= 1'b0;
      cnt     <= '0;
    end else if (cyc_start) begin
      waiting <= 1'b1;
      cnt     <= '0;
    end else if (dev_ack || tmo_irq) begin
      waiting <= 1'b0;
    end else if (waiting && !at_limit) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        tmo_status <= 1'b0;
    else if (tmo_irq)  tmo_status <= 1'b1;
    else if (flag_clr) tmo_status <= 1'b0;
  end

  a_r2_no_early: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start |=> !tmo_irq);
  a_r3_ack_cancels: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && dev_ack && !cyc_start) |=> !tmo_irq);
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_irq |=> !tmo_irq);
  a_r6_strap_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!strap_en && !tmo_status) |=> !tmo_status);
  a_r7_sticky_set: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_irq |=> tmo_status);
  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !tmo_irq) |=> !tmo_status);
endmodule

// File: tb/test_bus_ack_watchdog.sv
module test_bus_ack_watchdog;
  localparam int unsigned CLK_HZ    = 2_000_000;
  localparam int unsigned WINDOW_US = 4;
  localparam int LIM = (CLK_HZ / 1_000_000) * WINDOW_US; // R8: 8 cycles

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cyc_start = 1'b0, dev_ack = 1'b0, strap_en = 1'b1, flag_clr = 1'b0;
  logic cpu_ready, tmo_irq, tmo_status;
  int errors = 0, checks = 0;
  logic exp_status = 1'b0;

  always #2.5 clk = ~clk;

  bus_ack_watchdog #(.CLK_HZ(CLK_HZ), .WINDOW_US(WINDOW_US)) i_bus_ack_watchdog (
    .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .dev_ack(dev_ack),
    .strap_en(strap_en), .flag_clr(flag_clr), .cpu_ready(cpu_ready),
    .tmo_irq(tmo_irq), .tmo_status(tmo_status));

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // Strobe at one edge, then ack in cycle d after it (d=0: never); checks every cycle.
  task automatic run(input int d, input int extra);
    @(negedge clk) cyc_start = 1'b1;
    @(negedge clk) cyc_start = 1'b0;
    for (int j = 1; j <= LIM + extra; j++) begin
      if (j > 1) @(negedge clk);
      dev_ack = (j == d);
      #1;
      begin
        logic fire;
        fire = strap_en && (j == LIM) && (d == 0 || d > LIM);
        chk("R2/R3/R4 irq", tmo_irq, fire);
        chk("R2/R3/R6 ready", cpu_ready, fire || (j == d));
        if (fire) exp_status = 1'b1;
      end
    end
    @(negedge clk) dev_ack = 1'b0;
    #1 chk("R7 status held", tmo_status, exp_status);
  endtask

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1;
    chk("R1 ready in reset", cpu_ready, 1'b0);
    chk("R1 irq in reset", tmo_irq, 1'b0);
    chk("R1 status in reset", tmo_status, 1'b0);
    @(negedge clk); @(negedge clk) rst_n = 1'b1;
    @(negedge clk) #1;
    chk("R1 status after reset", tmo_status, 1'b0);
    chk("R1 irq after reset", tmo_irq, 1'b0);

    for (int s = 1; s >= 0; s--) begin
      strap_en = s[0];
      for (int d = 0; d <= LIM + 3; d++) begin
        run(d, 4);
        @(negedge clk) flag_clr = 1'b1;
        @(negedge clk) flag_clr = 1'b0;
        exp_status = 1'b0;
        #1 chk("R7 cleared", tmo_status, 1'b0);
      end
    end

    // R5: restart in mid-window, then time out LIM cycles after the second strobe
    strap_en = 1'b1;
    @(negedge clk) cyc_start = 1'b1;
    @(negedge clk) cyc_start = 1'b0;
    repeat (4) @(negedge clk);
    run(0, 3);

    // R7: status set and held with no clear, then a second timeout
    run(0, 2);
    chk("R7 sticky across cycles", tmo_status, 1'b1);
    @(negedge clk) flag_clr = 1'b1;
    @(negedge clk) flag_clr = 1'b0;
    #1 chk("R7 clear after hold", tmo_status, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule